// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one load, store or atomic request covering a warp of 32 lanes and turns it into the smallest serial sequence of aligned 128-byte line transactions. Each lane supplies its own address. A lane-active mask selects the lanes that take part. One access size applies to every lane. The block latches the request and checks each active lane for natural alignment. It then emits one line transaction per distinct line over a valid/ready handshake. Each transaction carries the line base address, the mask of lanes it serves, and each lane's byte offset inside the line.

When several lanes access the same address, the result depends on the operation. A load serves all of those lanes with one access (broadcast). A store keeps only the highest-numbered lane as the single writer. An atomic is split so that each duplicate lane gets its own transaction. Lines are emitted in the order of the lowest lane that touches each one. While a warp is in flight the request side is held off, so warps never overlap.

The cache, the memory and the data return path sit outside this block. It does only the address grouping and the lane bookkeeping.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, line_valid is 0 and err_lanes is all zero.
- R2: Size code 0,1,2,3,4 means 1,2,4,8,16 bytes per lane. Codes 5 to 7 flag every active lane. An active lane whose address is not a multiple of the size is flagged in err_lanes (bit i for lane i) and takes no part in any transaction. err_lanes is valid from the cycle after acceptance until the next acceptance.
- R3: For loads and stores, exactly one transaction is issued per distinct 128-byte line touched by a surviving lane. line_addr is the line base, with its low 7 bits zero.
- R4: Transactions leave in ascending order of the lowest surviving lane that touches each line.
- R5: Op code 0 (load), and the spare code 3, which acts as a load: a transaction's line_mask holds every surviving lane in that line, duplicates included (broadcast).
- R6: Op code 1 (store): among lanes with identical addresses, only the highest-numbered lane appears in any line_mask.
- R7: Op code 2 (atomic): lanes with identical addresses go out in separate transactions, in ascending lane order. Lanes in the same line with distinct addresses share a transaction.
- R8: line_offs field i, at bits [7i+6:7i], equals lane i's address modulo 128 when lane i is in line_mask, and is zero otherwise.
- R9: While line_valid is 1 and line_ready is 0, line_addr and line_mask hold steady. line_last is 1 exactly on the final transaction of a warp.
- R10: req_ready is 0 from the cycle after an acceptance while any transaction is still owed. It is 1 again the cycle after the last one is accepted. A warp with no surviving lanes issues nothing and leaves req_ready at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block can accept a warp |
| req_op | input | 2 | 0 load, 1 store, 2 atomic, 3 load |
| req_size | input | 3 | Access size code, 2^code bytes |
| req_mask | input | 32 | Lane-active mask |
| req_addr | input | 1024 | Lane i byte address at [32i+31:32i] |
| err_lanes | output | 32 | Misaligned or bad-size lanes of the last accepted warp |
| line_valid | output | 1 | Line transaction present |
| line_ready | input | 1 | Downstream accepts the transaction |
| line_addr | output | 32 | Line base address |
| line_mask | output | 32 | Lanes served by this transaction |
| line_offs | output | 224 | Per-lane 7-bit byte offset inside the line |
| line_last | output | 1 | Final transaction of the warp |

## Verification
The bench targets the cases where a grouping slip changes the transaction count. Sixteen 8-byte lanes straddling a line boundary must give two transactions; a design that grouped by the first address only would give one or sixteen. Same-address warps are issued as load, store and atomic. A wrong rule would show up as a store mask holding the lowest lane or several lanes, or as atomics merged into one transaction. Misaligned lanes, bad size codes and empty masks check that dropped lanes never reach a mask, and out-of-order line touches check that the emission order follows the lowest lane rather than the address.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ATOMIC = 2'd2,
        OP_SPARE  = 2'd3
    } op_e;

    localparam int unsigned MAX_SIZE_CODE = 4;

    function automatic logic size_code_ok(input logic [2:0] code);
        return code <= 3'(MAX_SIZE_CODE);
    endfunction

    // low-address bits that must be zero for a naturally aligned access
    function automatic logic [3:0] align_bits(input logic [2:0] code);
        logic [4:0] bytes;
        bytes = 5'd1 << code[1:0];
        if (code == 3'd4) bytes = 5'd16;
        return 4'(bytes - 5'd1);
    endfunction
endpackage

// File: rtl/wc_align_check.sv
module wc_align_check #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    input  logic [LANES-1:0]             active,
    input  logic [2:0]                   size_code,
    output logic [LANES-1:0]             good,
    output logic [LANES-1:0]             bad
);
    import wc_pkg::*;

    logic       size_ok;
    logic [3:0] amask;

    assign size_ok = size_code_ok(size_code);
    assign amask   = align_bits(size_code);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic aligned;
        assign aligned = size_ok && ((addr[g][3:0] & amask) == 4'd0);
        assign good[g] = active[g] && aligned;
        assign bad[g]  = active[g] && !aligned;
    end
endmodule

// File: rtl/wc_dup_matrix.sv
module wc_dup_matrix #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    output logic [LANES-1:0][LANES-1:0]  same
);
    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            if (i == j) begin : g_diag
                assign same[i][j] = 1'b1;
            end else begin : g_cmp
                assign same[i][j] = (addr[i] == addr[j]);
            end
        end
    end
endmodule

// File: rtl/wc_group_select.sv
module wc_group_select #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7
) (
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    input  logic [LANES-1:0][LANES-1:0]  same,
    input  wc_pkg::op_e                  op,
    output logic [ADDR_W-1:0]            base,
    output logic [LANES-1:0]             emit,
    output logic [LANES-1:0]             consume,
    output logic [LANES*OFF_W-1:0]       offs
);
    import wc_pkg::*;

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IDX_W-1:0]  lead_idx;
    logic [ADDR_W-1:0] lead_addr;
    logic [LANES-1:0]  cand;

    always_comb begin
        lead_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) lead_idx = IDX_W'(i);
        end
        lead_addr = addr[lead_idx];
        base      = {lead_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        for (int i = 0; i < LANES; i++) begin
            cand[i] = pending[i] &&
                      (addr[i][ADDR_W-1:OFF_W] == lead_addr[ADDR_W-1:OFF_W]);
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic dup_above;
            logic dup_below;
            dup_above = 1'b0;
            dup_below = 1'b0;
            for (int j = 0; j < LANES; j++) begin
                if (j > i && cand[j] && same[i][j]) dup_above = 1'b1;
                if (j < i && cand[j] && same[i][j]) dup_below = 1'b1;
            end
            case (op)
                OP_STORE:  emit[i] = cand[i] && !dup_above;
                OP_ATOMIC: emit[i] = cand[i] && !dup_below;
                default:   emit[i] = cand[i];
            endcase
        end
        consume = (op == OP_ATOMIC) ? emit : cand;
        for (int i = 0; i < LANES; i++) begin
            offs[i*OFF_W +: OFF_W] = emit[i] ? addr[i][OFF_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic [1:0]                         req_op,
    input  logic [2:0]                         req_size,
    input  logic [LANES-1:0]                   req_mask,
    input  logic [LANES*ADDR_W-1:0]            req_addr,
    output logic [LANES-1:0]                   err_lanes,
    output logic                               line_valid,
    input  logic                               line_ready,
    output logic [ADDR_W-1:0]                  line_addr,
    output logic [LANES-1:0]                   line_mask,
    output logic [LANES*$clog2(LINE_BYTES)-1:0] line_offs,
    output logic                               line_last
);
    import wc_pkg::*;

    localparam int OFF_W = $clog2(LINE_BYTES);

    typedef struct packed {
        logic [LANES-1:0]             pend;
        logic [LANES-1:0]             err;
        op_e                          op;
        logic [LANES-1:0][ADDR_W-1:0] addr;
    } state_t;

    state_t state_d, state_q;

    logic [LANES-1:0][ADDR_W-1:0] in_addr;
    logic [LANES-1:0]             in_good, in_bad;
    logic [LANES-1:0][LANES-1:0]  same;
    logic [LANES-1:0]             emit, consume;
    logic [ADDR_W-1:0]            base;
    logic [LANES*OFF_W-1:0]       offs;
    logic                         accept, fire;

    assign in_addr = req_addr;

    wc_align_check #(.LANES(LANES), .ADDR_W(ADDR_W)) i_align (
        .addr(in_addr), .active(req_mask), .size_code(req_size),
        .good(in_good), .bad(in_bad)
    );

    wc_dup_matrix #(.LANES(LANES), .ADDR_W(ADDR_W)) i_dup (
        .addr(state_q.addr), .same(same)
    );

    wc_group_select #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_group (
        .pending(state_q.pend), .addr(state_q.addr), .same(same),
        .op(state_q.op), .base(base), .emit(emit), .consume(consume),
        .offs(offs)
    );

    always_comb begin
        state_d    = state_q;
        req_ready  = (state_q.pend == '0);
        line_valid = (state_q.pend != '0);
        line_addr  = base;
        line_mask  = emit;
        line_offs  = offs;
        line_last  = ((state_q.pend & ~consume) == '0);
        err_lanes  = state_q.err;
        accept     = req_valid && req_ready;
        fire       = line_valid && line_ready;
        if (accept) begin
            state_d.pend = in_good;
            state_d.err  = in_bad;
            state_d.op   = op_e'(req_op);
            state_d.addr = in_addr;
        end else if (fire) begin
            state_d.pend = state_q.pend & ~consume;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && !line_ready |=> line_valid && $stable(line_addr) && $stable(line_mask)); // R9
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> !req_ready); // R10
    AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && line_ready && line_last |=> req_ready); // R10
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> line_mask != '0); // R4
    AST_ERR_NEVER_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_mask & err_lanes) == '0); // R2
    AST_LINE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && line_ready && !line_last && state_q.op != OP_ATOMIC
        |=> line_addr != $past(line_addr)); // R3
    AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && line_ready && !line_last |=> (line_mask & $past(line_mask)) == '0); // R4
endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int OW    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = '0;
    logic [2:0] req_size = '0;
    logic [LANES-1:0] req_mask = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES-1:0] err_lanes;
    logic line_valid;
    logic line_ready = 1'b0;
    logic [AW-1:0] line_addr;
    logic [LANES-1:0] line_mask;
    logic [LANES*OW-1:0] line_offs;
    logic line_last;

    always #2 clk = ~clk;

    warp_coalescer #(.LANES(LANES), .ADDR_W(AW), .LINE_BYTES(128)) i_warp_coalescer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_size(req_size), .req_mask(req_mask), .req_addr(req_addr),
        .err_lanes(err_lanes), .line_valid(line_valid), .line_ready(line_ready),
        .line_addr(line_addr), .line_mask(line_mask), .line_offs(line_offs),
        .line_last(line_last)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [AW-1:0] w_addr [LANES];
    logic [LANES-1:0] w_mask;
    logic [1:0] w_op;
    logic [2:0] w_size;

    logic [AW-1:0] e_addr [LANES];
    logic [LANES-1:0] e_mask [LANES];
    logic [LANES-1:0] e_err;
    int e_n;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string mask_tag(input logic [1:0] op);
        if (op == 2'd1) return "R6";
        if (op == 2'd2) return "R7";
        return "R5";
    endfunction

    function automatic void build_expected();
        logic [LANES-1:0] pend;
        logic [LANES-1:0] cand, keep, used;
        int bytes, lead;
        bit dup;
        pend = '0; e_err = '0; e_n = 0;
        bytes = 1 << w_size;
        for (int i = 0; i < LANES; i++) begin
            if (w_mask[i]) begin
                if (w_size > 3'd4 || (w_addr[i] % bytes) != 0) e_err[i] = 1'b1;
                else pend[i] = 1'b1;
            end
        end
        while (pend != '0) begin
            lead = 0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
            cand = '0;
            for (int i = 0; i < LANES; i++)
                if (pend[i] && (w_addr[i] >> 7) == (w_addr[lead] >> 7)) cand[i] = 1'b1;
            keep = '0;
            for (int i = 0; i < LANES; i++) begin
                dup = 0;
                for (int j = 0; j < LANES; j++) begin
                    if (cand[j] && w_addr[j] == w_addr[i]) begin
                        if (w_op == 2'd1 && j > i) dup = 1;
                        if (w_op == 2'd2 && j < i) dup = 1;
                    end
                end
                keep[i] = cand[i] && !dup;
            end
            used = (w_op == 2'd2) ? keep : cand;
            e_addr[e_n] = {w_addr[lead][AW-1:7], 7'd0};
            e_mask[e_n] = keep;
            e_n++;
            pend = pend & ~used;
        end
    endfunction

    task automatic run_warp(input bit stall);
        int k, guard;
        logic [AW-1:0] held_addr;
        logic [LANES-1:0] held_mask;
        bit was_stalled;
        logic [LANES*OW-1:0] eo;
        build_expected();
        @(negedge clk);
        check(req_ready === 1'b1, "R10", "ready before warp", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_op = w_op; req_size = w_size; req_mask = w_mask;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = w_addr[i];
        @(negedge clk);
        req_valid = 1'b0;
        check(err_lanes === e_err, "R2", "err_lanes", 64'(err_lanes), 64'(e_err));
        if (e_n > 0)
            check(req_ready === 1'b0, "R10", "ready low while busy", 64'(req_ready), 64'd0);
        k = 0; guard = 0; was_stalled = 0;
        held_addr = '0; held_mask = '0;
        while (k < e_n && guard < 400) begin
            line_ready = stall ? ($urandom % 3 != 0) : 1'b1;
            #1;
            if (was_stalled) begin
                check(line_valid === 1'b1 && line_addr === held_addr && line_mask === held_mask,
                      "R9", "held while stalled", 64'(line_addr), 64'(held_addr));
            end
            was_stalled = 0;
            if (line_valid && !line_ready) begin
                was_stalled = 1; held_addr = line_addr; held_mask = line_mask;
            end
            if (line_valid && line_ready) begin
                check(line_addr === e_addr[k], "R3", "line_addr", 64'(line_addr), 64'(e_addr[k]));
                check(line_mask === e_mask[k], mask_tag(w_op), "line_mask", 64'(line_mask), 64'(e_mask[k]));
                eo = '0;
                for (int i = 0; i < LANES; i++)
                    if (e_mask[k][i]) eo[i*OW +: OW] = w_addr[i][6:0];
                check(line_offs === eo, "R8", "line_offs", 64'(line_offs), 64'(eo));
                check(line_last === (k == e_n - 1), "R9", "line_last",
                      64'(line_last), 64'(k == e_n - 1));
                k++;
            end
            @(negedge clk);
            guard++;
        end
        line_ready = 1'b0;
        check(k == e_n, "R4", "transaction count", 64'(k), 64'(e_n));
        check(req_ready === 1'b1 && line_valid === 1'b0, "R10", "idle after warp",
              64'({req_ready, line_valid}), 64'b10);
    endtask

    task automatic clear_warp();
        w_mask = '0; w_op = 2'd0; w_size = 3'd2;
        for (int i = 0; i < LANES; i++) w_addr[i] = '0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        check(line_valid === 1'b0, "R1", "reset line_valid", 64'(line_valid), 64'd0);
        check(err_lanes === '0, "R1", "reset err", 64'(err_lanes), 64'd0);
        rst_n = 1'b1;

        // R3: sixteen 8-byte lanes straddling a boundary give two lines
        clear_warp(); w_size = 3'd3; w_mask = 32'h0000_FFFF;
        for (int i = 0; i < 16; i++) w_addr[i] = 32'd112 + 32'(i * 8);
        run_warp(0);
        check(e_n == 2, "R3", "straddle count", 64'(e_n), 64'd2);

        // R5: broadcast load
        clear_warp(); w_mask = '1;
        for (int i = 0; i < LANES; i++) w_addr[i] = 32'h2040;
        run_warp(1);

        // R6: store winner is the highest lane
        clear_warp(); w_op = 2'd1; w_mask = 32'h7FFF_FFFF;
        for (int i = 0; i < LANES; i++) w_addr[i] = 32'h3008;
        run_warp(1);

        // R7: atomics to one address serialize
        clear_warp(); w_op = 2'd2; w_mask = 32'h0000_00F1;
        for (int i = 0; i < LANES; i++) w_addr[i] = 32'h4010;
        w_addr[5] = 32'h4020;
        run_warp(1);

        // R2: misaligned lane and bad size code
        clear_warp(); w_mask = 32'h0000_000F;
        w_addr[0] = 32'h100; w_addr[1] = 32'h104; w_addr[2] = 32'h10A; w_addr[3] = 32'h10C;
        run_warp(0);
        w_size = 3'd6;
        run_warp(0);

        // R10: empty mask gives no transaction
        clear_warp(); run_warp(0);

        // R4: order follows lowest lane, not address
        clear_warp(); w_mask = 32'h0000_0007;
        w_addr[0] = 32'h900; w_addr[1] = 32'h100; w_addr[2] = 32'h904;
        run_warp(1);

        for (int n = 0; n < 300; n++) begin
            int bytes, base_line;
            w_op = 2'($urandom % 4);
            w_size = 3'($urandom % 5);
            if ($urandom % 25 == 0) w_size = 3'd7;
            w_mask = $urandom;
            bytes = 1 << (w_size > 3'd4 ? 0 : w_size);
            base_line = 32'($urandom % 16);
            for (int i = 0; i < LANES; i++) begin
                w_addr[i] = 32'((base_line + ($urandom % 4)) * 128 +
                                (($urandom % (128 / bytes)) % 3) * bytes);
                if ($urandom % 2 == 0) w_addr[i] = 32'(w_addr[i] + ($urandom % (128 / bytes)) * bytes);
                w_addr[i][6:0] = w_addr[i][6:0] & ~7'(bytes - 1);
                if (bytes > 1 && $urandom % 30 == 0) w_addr[i] = w_addr[i] + 32'd1;
            end
            run_warp(n % 2 == 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule